// File: doc/BRIEF.md
# Reference-Clock Period Meter with Stall Detection

This block measures the period of a slow, asynchronous input clock in cycles of a faster reference clock. It brings the input into the reference domain through a synchroniser and detects its rising edges. It then counts reference cycles from one rising edge to the next and reports that span as the latest period, together with a valid flag and a one-cycle update strobe. Only rising edges take part, so the result is a full period whatever the duty cycle.

A stall watchdog shares the span counter. If the input shows no rising edge within a programmable number of reference cycles, the block declares the input dead. The period then reads zero, which means zero frequency. The watchdog also forgets the last edge it saw, so the first edge after a stall only re-arms the meter and cannot produce a bogus, overlong period. Choose the timeout longer than the slowest expected input period.

Top module: `pm_period_meter`

## Requirements
- R1: While reset is asserted and right after it is released, period_o is 0 and valid_o, dead_o and upd_o are all 0.
- R2: After two consecutive rising edges of meas_clk_i, period_o equals the number of reference cycles between them, whatever the high and low times. Falling edges have no effect.
- R3: Each new period raises upd_o for exactly one reference cycle, with valid_o high and period_o already holding the new value.
- R4: The first rising edge after reset, or after a stall, produces no update and leaves valid_o low.
- R5: If no rising edge arrives for more than TIMEOUT_CYC reference cycles, dead_o goes high and stays high, valid_o goes low and period_o reads 0. Measured from the input edge, dead_o rises no earlier than TIMEOUT_CYC cycles and no later than TIMEOUT_CYC+3 cycles, which allows for synchroniser latency.
- R6: A span of exactly TIMEOUT_CYC cycles is still reported as a period. A span of TIMEOUT_CYC+1 cycles counts as a stall and produces no update.
- R7: Any rising edge clears dead_o within three reference cycles.
- R8: An input not aligned to the reference clock passes through a SYNC_STAGES-flop synchroniser. Each reported period is within ±1 cycle of the true period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| meas_clk_i | input | 1 | Asynchronous clock being measured |
| period_o | output | CNT_W | Latest period in reference cycles, 0 when dead |
| valid_o | output | 1 | period_o holds a real measurement |
| dead_o | output | 1 | No rising edge within the timeout |
| upd_o | output | 1 | One-cycle strobe for each new period |

## Verification
The bench drives strongly asymmetric waveforms: short-high, short-low and balanced. A meter that counted both edges would report half or odd fractions of the period there. It stalls the input before each train and then checks that the first edge yields no update. A design that kept the stale edge would report a huge span at that point. The boundary trains use spans of exactly the timeout and one cycle more. They catch an off-by-one in the saturation compare, which would either drop legal periods or accept stalled ones. A timing probe checks that dead_o rises in the right window after the last edge, and an unaligned input checks the ±1 tolerance.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Events passed from the front end and span counter to the result stage.
  typedef struct packed {
    logic rise;     // synchronised rising edge of the measured clock
    logic expired;  // span counter saturated with no edge this cycle
  } pm_evt_t;

  // Counter width able to hold the timeout limit itself.
  function automatic int unsigned pm_cnt_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              hist_q;
  logic              hist_d;

  // Shift chain, one flop per stage.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_d[i] = async_i;
    end else begin : g_rest
      assign stage_d[i] = stage_q[i-1];
    end
  end

  always_comb begin
    hist_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      hist_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      hist_q  <= hist_d;
    end
  end

  assign rise_o = stage_q[STAGES-1] & ~hist_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);  // R2

endmodule

// File: rtl/pm_span_counter.sv
module pm_span_counter #(
  parameter int unsigned LIMIT = 64,
  parameter int unsigned W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] span_o,
  output logic         expired_o
);

  localparam logic [W-1:0] LIM_V = W'(LIMIT);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] span_q;
  logic [W-1:0] span_d;
  logic         at_lim;
  logic         span_en;

  always_comb begin
    at_lim  = (span_q == LIM_V);
    span_en = restart_i | ~at_lim;
    if (restart_i) begin
      span_d = ONE_V;
    end else begin
      span_d = span_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
    end else if (span_en) begin
      span_q <= span_d;
    end
  end

  assign span_o    = span_q;
  assign expired_o = at_lim & ~restart_i;

  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    span_q <= LIM_V);  // R6
  AST_SPAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (span_q == ONE_V));  // R2

endmodule

// File: rtl/pm_result.sv
module pm_result
  import pm_pkg::*;
#(
  parameter int unsigned LIMIT = 64,
  parameter int unsigned W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pm_evt_t      evt_i,
  input  logic [W-1:0] span_i,
  output logic [W-1:0] period_o,
  output logic         valid_o,
  output logic         dead_o,
  output logic         upd_o
);

  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic         armed_q, armed_d;
  logic         valid_q, valid_d;
  logic         dead_q,  dead_d;
  logic         upd_q,   upd_d;
  logic [W-1:0] period_q, period_d;
  logic         period_en;

  always_comb begin
    armed_d   = armed_q;
    valid_d   = valid_q;
    dead_d    = dead_q;
    upd_d     = 1'b0;
    period_d  = period_q;
    period_en = 1'b0;
    if (evt_i.expired) begin
      armed_d   = 1'b0;
      valid_d   = 1'b0;
      dead_d    = 1'b1;
      period_d  = '0;
      period_en = 1'b1;
    end else if (evt_i.rise) begin
      armed_d = 1'b1;
      dead_d  = 1'b0;
      if (armed_q) begin
        period_d  = span_i;
        period_en = 1'b1;
        valid_d   = 1'b1;
        upd_d     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      dead_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      valid_q <= valid_d;
      dead_q  <= dead_d;
      upd_q   <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (period_en) begin
      period_q <= period_d;
    end
  end

  assign period_o = period_q;
  assign valid_o  = valid_q;
  assign dead_o   = dead_q;
  assign upd_o    = upd_q;

  AST_UPD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> valid_q);  // R3
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);  // R3
  AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.rise && !armed_q) |=> !upd_q);  // R4
  AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |-> (!valid_q && period_q == '0));  // R5
  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (period_q >= W'(2) && period_q <= LIM_V));  // R6
  AST_RISE_REVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.rise |=> !dead_q);  // R7

endmodule

// File: rtl/pm_period_meter.sv
module pm_period_meter
  import pm_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = pm_cnt_width(TIMEOUT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_clk_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o,
  output logic             dead_o,
  output logic             upd_o
);

  pm_evt_t          evt;
  logic             rise;
  logic             expired;
  logic [CNT_W-1:0] span;

  pm_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (meas_clk_i),
    .rise_o  (rise)
  );

  pm_span_counter #(
    .LIMIT (TIMEOUT_CYC),
    .W     (CNT_W)
  ) span_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (rise),
    .span_o    (span),
    .expired_o (expired)
  );

  always_comb begin
    evt.rise    = rise;
    evt.expired = expired;
  end

  pm_result #(
    .LIMIT (TIMEOUT_CYC),
    .W     (CNT_W)
  ) res_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt),
    .span_i   (span),
    .period_o (period_o),
    .valid_o  (valid_o),
    .dead_o   (dead_o),
    .upd_o    (upd_o)
  );

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && expired));  // R5

endmodule

// File: tb/pm_period_meter_tb.sv
module pm_period_meter_tb_top;

  localparam int unsigned T = 64;
  localparam int unsigned W = $clog2(T + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         meas = 1'b0;
  logic [W-1:0] period;
  logic         valid;
  logic         dead;
  logic         upd;

  int n_chk = 0;
  int n_bad = 0;
  int upd_cnt = 0;
  int exp_lo = 0;
  int exp_hi = 0;

  always #10 clk = ~clk;

  pm_period_meter #(
    .TIMEOUT_CYC (T),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_clk_i (meas),
    .period_o   (period),
    .valid_o    (valid),
    .dead_o     (dead),
    .upd_o      (upd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Collect every update strobe, sampled mid-cycle. R2 R3 R8
  always @(negedge clk) begin
    if (rst_n && upd) begin
      upd_cnt++;
      chk(int'(period) >= exp_lo && int'(period) <= exp_hi, "R2/R8 period", int'(period), exp_lo);
      chk(valid == 1'b1, "R3 valid with strobe", int'(valid), 1);
    end
  end

  task automatic t_reset;
    chk(period == '0, "R1 period", int'(period), 0);
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(dead == 1'b0, "R1 dead", int'(dead), 0);
    chk(upd == 1'b0, "R1 upd", int'(upd), 0);
  endtask

  task automatic t_first_after_reset;
    upd_cnt = 0;
    @(negedge clk);
    meas = 1'b1;
    repeat (5) @(negedge clk);
    meas = 1'b0;
    repeat (10) @(negedge clk);
    chk(upd_cnt == 0, "R4 no update on first edge", upd_cnt, 0);
    chk(valid == 1'b0, "R4 valid stays low", int'(valid), 0);
  endtask

  task automatic t_stall;
    meas = 1'b0;
    repeat (T + 8) @(posedge clk);
    @(negedge clk);
    chk(dead == 1'b1, "R5 dead", int'(dead), 1);
    chk(valid == 1'b0, "R5 valid", int'(valid), 0);
    chk(period == '0, "R5 period zero", int'(period), 0);
  endtask

  task automatic t_train(input int hi, input int lo, input int n, input int exp_upd, input string req);
    upd_cnt = 0;
    exp_lo  = hi + lo;
    exp_hi  = hi + lo;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      meas = 1'b1;
      repeat (hi) @(negedge clk);
      meas = 1'b0;
      repeat (lo) @(negedge clk);
    end
    chk(upd_cnt == exp_upd, {req, " update count"}, upd_cnt, exp_upd);
    chk(valid == (exp_upd > 0), {req, " valid"}, int'(valid), int'(exp_upd > 0));
    if (hi + lo < int'(T)) begin
      chk(dead == 1'b0, "R7 dead cleared", int'(dead), 0);
    end
  endtask

  task automatic t_unaligned;
    upd_cnt = 0;
    exp_lo  = 12;
    exp_hi  = 13;
    @(negedge clk);
    #7;
    for (int k = 0; k < 6; k++) begin
      meas = 1'b1;
      #90;
      meas = 1'b0;
      #160;
    end
    @(negedge clk);
    chk(upd_cnt == 5, "R8 unaligned update count", upd_cnt, 5);
  endtask

  task automatic t_dead_timing;
    upd_cnt = 0;
    @(negedge clk);
    meas = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dead == 1'b0, "R7 edge clears dead", int'(dead), 0);
    chk(valid == 1'b0, "R4 first edge after stall", int'(valid), 0);
    chk(upd_cnt == 0, "R4 no update after stall", upd_cnt, 0);
    repeat (T - 3) @(posedge clk);
    @(negedge clk);
    chk(dead == 1'b0, "R5 dead not early", int'(dead), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dead == 1'b1, "R5 dead on time", int'(dead), 1);
    meas = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_after_reset();
    t_stall();
    t_train(2, 10, 5, 4, "R2 short high");
    t_stall();
    t_train(9, 3, 5, 4, "R2 short low");
    t_stall();
    t_train(15, 15, 4, 3, "R2 balanced");
    t_stall();
    t_train(10, int'(T) - 10, 3, 2, "R6 span at limit");
    t_stall();
    t_train(10, int'(T) - 9, 3, 0, "R6 span over limit");
    t_stall();
    t_unaligned();
    t_stall();
    t_dead_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule